// File: doc/BRIEF.md
# Shared Fault Line Group Controller

This block ties one power channel to an open-drain fault line that several channels share as a wired-AND. When the channel's own fault detector fires, the block latches the fault. It turns the channel off and, if the channel is set to propagate faults, pulls the shared line low. Every channel that is set to listen to the line shuts down while the line is low. As a result, one fault takes down the whole group.

Two recovery modes are available. In retry mode, the faulted channel lets go of the line once a retry interval has elapsed, but only if its fault has gone away by then. Every listening channel then restarts together and fires a soft-start pulse. In latch-off mode, the line stays pulled until the run input or the on/off command goes off and then on again. A configuration bit makes a run toggle also clear the latched faults of the sibling channels. It does this through a one-cycle clear pulse that those channels receive on their peer-clear input.

Top module: `fault_grp_ctrl`

## Requirements
- R1: After reset, chan_en_o, pulldown_o, ss_start_o and run_clr_o are all 0, no fault is latched, and the line synchronizer reads the line as released (high).
- R2: With fault_i high at a clock edge, the fault is latched at that edge. chan_en_o is 0 after it, and pulldown_o is 1 after it only when prop_en_i is 1.
- R3: line_i (1 = released, 0 = pulled low) passes through a two-flop synchronizer. With resp_en_i at 1, a low line forces chan_en_o to 0 at the third edge after the change. With resp_en_i at 0, the line has no effect on chan_en_o.
- R4: With resp_mode_i at 0 (retry), a fault latched at edge k is released at edge k+RETRY_CYC if fault_i is 0 at that edge. If fault_i is still 1 there, a new interval of RETRY_CYC edges starts.
- R5: chan_en_o rises whenever the run conditions return; this includes the release of the shared line after a retry. ss_start_o is high for exactly the one cycle in which chan_en_o first becomes 1.
- R6: With resp_mode_i at 1 (latch-off), a latched fault is kept for any length of time. It is cleared only by a run_i 0-to-1 edge, a cmd_on_i 0-to-1 edge, or peer_clr_i.
- R7: A clear event that occurs while fault_i is still 1 does not clear the fault.
- R8: With clr_all_i at 1, a run_i 0-to-1 edge makes run_clr_o high for one cycle, at the edge that samples run_i high. A cmd_on_i edge never does this, and neither does any edge while clr_all_i is 0.
- R9: peer_clr_i high at an edge clears this channel's latched fault, provided fault_i is 0.
- R10: chan_en_o is 1 only while run_i and cmd_on_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Internal fault flag of this channel |
| line_i | input | 1 | Sensed level of the shared fault line, 1 = released |
| run_i | input | 1 | Run input |
| cmd_on_i | input | 1 | On/off command, 1 = on |
| prop_en_i | input | 1 | Channel pulls the line on its own fault |
| resp_en_i | input | 1 | Channel shuts down while the line is low |
| resp_mode_i | input | 1 | Fault response: 0 = retry, 1 = latch-off |
| clr_all_i | input | 1 | Run toggle also clears sibling channels |
| peer_clr_i | input | 1 | Clear request from a sibling channel |
| pulldown_o | output | 1 | Open-drain pull-down enable for the shared line |
| chan_en_o | output | 1 | Channel output enable |
| ss_start_o | output | 1 | One-cycle soft-start request |
| run_clr_o | output | 1 | One-cycle clear request to sibling channels |

## Verification
A stuck or wrongly cleared fault latch shows up on pulldown_o at the first edge after the fault or the clear event. A retry counter that is off by one moves the release edge of pulldown_o by exactly one cycle, and the bench pins that edge down. A synchronizer with the wrong depth shifts the restart of chan_en_o away from the third edge after the line is released. A bad edge detector shows up either as a missing or extra run_clr_o pulse, or as a latch that does not clear, at the very next edge.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic {
    RESP_RETRY = 1'b0,
    RESP_LATCH = 1'b1
  } resp_mode_e;
endpackage

// File: rtl/fgc_sync.sv
module fgc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fgc_edge.sv
module fgc_edge #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] lvl_i,
  output logic [NUM-1:0] rise_o
);
  logic [NUM-1:0] prev_q;

  for (genvar g = 0; g < NUM; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end
endmodule

// File: rtl/fgc_retry_tmr.sv
module fgc_retry_tmr #(
  parameter int RETRY_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (RETRY_CYC < 2) ? 1 : $clog2(RETRY_CYC);
  localparam logic [CW-1:0] LAST = CW'(RETRY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expire_o = run_i & (cnt_q == LAST);
  assign cnt_en   = 1'b1;

  always_comb begin
    if (!run_i)        cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/fault_grp_ctrl.sv
module fault_grp_ctrl #(
  parameter int RETRY_CYC   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic line_i,
  input  logic run_i,
  input  logic cmd_on_i,
  input  logic prop_en_i,
  input  logic resp_en_i,
  input  logic resp_mode_i,
  input  logic clr_all_i,
  input  logic peer_clr_i,
  output logic pulldown_o,
  output logic chan_en_o,
  output logic ss_start_o,
  output logic run_clr_o
);
  import fgc_pkg::*;

  localparam int IDX_RUN = 0;
  localparam int IDX_CMD = 1;

  resp_mode_e mode;
  logic       line_s;
  logic [1:0] rise;
  logic       own_clr;
  logic       tmr_exp;
  logic       retry_ok;

  logic flt_q, flt_d;
  logic en_q, en_d;
  logic ss_q, ss_d;
  logic rc_q, rc_d;
  logic on_req, grp_hold;

  assign mode = resp_mode_e'(resp_mode_i);

  fgc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  fgc_edge #(.NUM(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i({cmd_on_i, run_i}), .rise_o(rise)
  );

  fgc_retry_tmr #(.RETRY_CYC(RETRY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .run_i(flt_q && (mode == RESP_RETRY)),
    .expire_o(tmr_exp)
  );

  assign own_clr  = rise[IDX_RUN] | rise[IDX_CMD] | peer_clr_i;
  assign retry_ok = tmr_exp & ~fault_i;
  assign on_req   = run_i & cmd_on_i;
  assign grp_hold = resp_en_i & ~line_s;

  always_comb begin
    if (fault_i) flt_d = 1'b1;
    else         flt_d = flt_q & ~own_clr & ~retry_ok;
    en_d = on_req & ~flt_d & ~grp_hold;
    ss_d = en_d & ~en_q;
    rc_d = rise[IDX_RUN] & clr_all_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      en_q  <= 1'b0;
      ss_q  <= 1'b0;
      rc_q  <= 1'b0;
    end else begin
      flt_q <= flt_d;
      en_q  <= en_d;
      ss_q  <= ss_d;
      rc_q  <= rc_d;
    end
  end

  assign pulldown_o = flt_q & prop_en_i;
  assign chan_en_o  = en_q;
  assign ss_start_o = ss_q;
  assign run_clr_o  = rc_q;

  a_r2_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> flt_q && !chan_en_o);
  a_r3_line_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_en_i && !line_s) |=> !chan_en_o);
  a_r4_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RESP_RETRY && $fell(flt_q)) |-> !$past(fault_i));
  a_r5_ss_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |-> chan_en_o);
  a_r5_ss_single: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |=> !ss_start_o);
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RESP_LATCH && flt_q && !own_clr) |=> flt_q);
  a_r10_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_i && cmd_on_i) |=> !chan_en_o);
endmodule

// File: tb/sim_fault_grp_ctrl.sv
`timescale 1ns/1ps
module sim_fault_grp_ctrl;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic fault_i, run_i, cmd_on_i, prop_en_i, resp_en_i, resp_mode_i;
  logic clr_all_i, peer_clr_i, peer_pull;
  logic line_i;
  logic pulldown_o, chan_en_o, ss_start_o, run_clr_o;

  always #2.5 clk = ~clk;

  assign line_i = ~(pulldown_o | peer_pull);

  fault_grp_ctrl #(.RETRY_CYC(L)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .line_i(line_i),
    .run_i(run_i), .cmd_on_i(cmd_on_i), .prop_en_i(prop_en_i),
    .resp_en_i(resp_en_i), .resp_mode_i(resp_mode_i), .clr_all_i(clr_all_i),
    .peer_clr_i(peer_clr_i), .pulldown_o(pulldown_o), .chan_en_o(chan_en_o),
    .ss_start_o(ss_start_o), .run_clr_o(run_clr_o)
  );

  typedef struct {
    string tag;
    int    sig;
    logic  val;
  } item_t;

  item_t q[$];
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  localparam int S_EN = 0, S_PD = 1, S_SS = 2, S_RC = 3;

  task automatic expect_o(input string tag, input int sig, input logic val);
    item_t it;
    it.tag = tag; it.sig = sig; it.val = val;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic act;
        it = q.pop_front();
        case (it.sig)
          S_EN:    act = chan_en_o;
          S_PD:    act = pulldown_o;
          S_SS:    act = ss_start_o;
          default: act = run_clr_o;
        endcase
        nchk++;
        if (act !== it.val) begin
          nfail++;
          $display("FAIL %s sig=%0d actual=%b expected=%b at %0t",
                   it.tag, it.sig, act, it.val, $time);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fault_i = 0; run_i = 0; cmd_on_i = 0; prop_en_i = 1;
    resp_en_i = 1; resp_mode_i = 0; clr_all_i = 0; peer_clr_i = 0; peer_pull = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    expect_o("R1", S_EN, 0); expect_o("R1", S_PD, 0);
    expect_o("R1", S_SS, 0); expect_o("R1", S_RC, 0);
    tick();

    // start up
    run_i = 1; cmd_on_i = 1;
    expect_o("R5 start", S_EN, 1); expect_o("R5 start", S_SS, 1);
    tick();
    expect_o("R5 single", S_SS, 0); tick();
    cmd_on_i = 0; expect_o("R10", S_EN, 0); tick();
    cmd_on_i = 1; expect_o("R10", S_EN, 1); expect_o("R10", S_SS, 1); tick();

    // retry with fault cleared in time
    fault_i = 1;
    expect_o("R2", S_PD, 1); expect_o("R2", S_EN, 0); tick();
    fault_i = 0;
    for (int i = 1; i < L; i++) begin expect_o("R4 hold", S_PD, 1); tick(); end
    expect_o("R4 release", S_PD, 0); tick();
    expect_o("R3 sync", S_EN, 0); tick();
    expect_o("R3 sync", S_EN, 0); tick();
    expect_o("R5 group", S_EN, 1); expect_o("R5 group", S_SS, 1); tick();

    // retry with fault persisting past first interval
    fault_i = 1; tick();
    for (int i = 1; i <= L; i++) begin expect_o("R4 persist", S_PD, 1); tick(); end
    fault_i = 0;
    for (int i = 1; i < L; i++) begin expect_o("R4 restart", S_PD, 1); tick(); end
    expect_o("R4 restart rel", S_PD, 0); tick();
    tick(); tick();
    expect_o("R5 restart", S_EN, 1); tick();

    // no propagation
    prop_en_i = 0; fault_i = 1;
    expect_o("R2 noprop", S_PD, 0); expect_o("R2 noprop", S_EN, 0); tick();
    fault_i = 0;
    repeat (L - 1) tick();
    expect_o("R4 noprop", S_EN, 1); expect_o("R5 noprop", S_SS, 1); tick();
    prop_en_i = 1;

    // line from another channel
    resp_en_i = 0; peer_pull = 1;
    tick(); tick(); tick();
    expect_o("R3 ignore", S_EN, 1); tick();
    resp_en_i = 1; expect_o("R3 listen", S_EN, 0); tick();
    peer_pull = 0; tick(); tick();
    expect_o("R5 line rel", S_EN, 1); expect_o("R5 line rel", S_SS, 1); tick();

    // latch-off, cleared by command toggle
    resp_mode_i = 1; fault_i = 1;
    expect_o("R6 set", S_PD, 1); tick();
    fault_i = 0;
    repeat (2 * L) tick();
    expect_o("R6 holds", S_PD, 1); tick();
    cmd_on_i = 0; tick();
    cmd_on_i = 1; expect_o("R6 cmd clr", S_PD, 0); tick();
    tick(); tick();
    expect_o("R6 back on", S_EN, 1); tick();

    // toggle while fault present
    fault_i = 1; tick();
    run_i = 0; tick();
    run_i = 1; expect_o("R7", S_PD, 1); tick();
    fault_i = 0; expect_o("R7 after", S_PD, 1); tick();
    run_i = 0; tick();
    run_i = 1; expect_o("R6 run clr", S_PD, 0); expect_o("R8 off", S_RC, 0); tick();
    repeat (4) tick();

    // clear-all broadcast
    clr_all_i = 1; run_i = 0; tick();
    run_i = 1; expect_o("R8 pulse", S_RC, 1); tick();
    expect_o("R8 one", S_RC, 0); tick();
    cmd_on_i = 0; tick();
    cmd_on_i = 1; expect_o("R8 cmd", S_RC, 0); tick();
    clr_all_i = 0;

    // peer clear
    fault_i = 1; tick();
    fault_i = 0; expect_o("R9 held", S_PD, 1); tick();
    peer_clr_i = 1; expect_o("R9 clr", S_PD, 0); tick();
    peer_clr_i = 0;
    repeat (3) tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule